// File: doc/BRIEF.md
# BCD Calendar Time Keeper

This block holds the time-of-day and calendar bytes of a PC-style real-time clock in packed BCD. Internally it counts seconds, minutes, hours, weekday, day, month and a four-digit year in binary. It publishes them as eight BCD bytes: seconds, minutes, hours, day-of-week, day-of-month, month, the year within its century, and the century.

A one-cycle pulse on `secTick` advances the time by one second. The carry runs through minutes, hours, days, months and years, and the month lengths follow the Gregorian leap-year rule. A one-cycle pulse on `loadEn` replaces every field at once with binary values from the load port. The load port uses a zero-based weekday and a zero-based month, and a full binary year.

Every accepted request starts a three-stage update. The valid flag drops, the bytes are rewritten, and then the flag returns. Software that reads the bytes while the flag is high always sees a consistent set.

Top module: `calTimeKeeper`

## Requirements
- R1: After reset the bytes read seconds 0x00, minutes 0x00, hours 0x00, day-of-week 0x07, day-of-month 0x01, month 0x01, year 0x00 and century 0x20. At that point `timeValid` is 1 and `hour24` is 1, and `hour24` stays 1 at all times.
- R2: Every output byte is packed BCD: the tens digit is in bits 7:4 and the units digit is in bits 3:0, and each nibble is at most 9.
- R3: An accepted tick adds one second. Seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00 and carry into the day. Hours stay in 24-hour form, with a range of 0x00 to 0x23.
- R4: Day-of-week is the zero-based weekday plus one, so Sunday reads 0x01 and Saturday reads 0x07. It advances by one on every day carry and wraps from 0x07 to 0x01.
- R5: The month byte ranges 0x01 to 0x12 and equals the zero-based load value plus one. A day carry out of December 31 gives January 1 and increments the year.
- R6: A day carry out of the last day of a month gives day 0x01 of the next month. Months 4, 6, 9 and 11 have 30 days and the other months except February have 31. February has 29 days when the year is divisible by 4, except that a year divisible by 100 must also be divisible by 400. Otherwise February has 28 days.
- R7: The year byte holds the full year modulo 100 and the century byte holds the full year divided by 100. A year carry from xx99 increments the century.
- R8: For a request accepted at clock edge k, `timeValid` is 0 after edge k while the bytes still hold their old values. The bytes take their new values at edge k+1, and `timeValid` returns to 1 at edge k+2. The bytes never change while `timeValid` is 1.
- R9: A load writes all seven fields in one update. When `loadEn` and `secTick` are both high in the same accepted cycle, the load wins and no second is added.
- R10: A tick or load that arrives while an update is in progress (`timeValid` low) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| loadEn | input | 1 | One-cycle pulse that loads the load-port values |
| loadSec | input | 6 | Seconds to load, binary 0..59 |
| loadMin | input | 6 | Minutes to load, binary 0..59 |
| loadHour | input | 5 | Hours to load, binary 0..23 |
| loadWday | input | 3 | Weekday to load, 0 = Sunday .. 6 = Saturday |
| loadMday | input | 5 | Day of month to load, 1..31 |
| loadMon | input | 4 | Month to load, 0 = January .. 11 = December |
| loadYear | input | YEAR_W (14) | Full year to load, binary 0..9999 |
| secBcd | output | 8 | Seconds, BCD |
| minBcd | output | 8 | Minutes, BCD |
| hourBcd | output | 8 | Hours (24-hour), BCD |
| dowBcd | output | 8 | Day of week 1..7, BCD |
| domBcd | output | 8 | Day of month, BCD |
| monBcd | output | 8 | Month 1..12, BCD |
| yearBcd | output | 8 | Year modulo 100, BCD |
| centBcd | output | 8 | Year divided by 100, BCD |
| timeValid | output | 1 | High when the bytes hold a complete, consistent time |
| hour24 | output | 1 | 24-hour mode indication, set from reset |

## Verification
Some properties can be checked on every cycle, and the assertions do so:
- every nibble is a decimal digit;
- each field stays within its legal range;
- `timeValid` falls after an accepted request, while the bytes have not yet moved;
- the bytes move only while `timeValid` is low;
- the 24-hour flag is held.

Other behaviour can only be shown by the bench's scenarios, which compare the bytes against a calendar model:
- the carry chain itself;
- month lengths, including the rule that a century year is leap only when divisible by 400;
- the century carry;
- the weekday wrap;
- a load winning over a coincident tick;
- requests dropped while an update is still in flight.

// File: rtl/calPkg.sv
package calPkg;

  // Byte slots of the published register set
  localparam int unsigned IDX_SEC  = 0;
  localparam int unsigned IDX_MIN  = 1;
  localparam int unsigned IDX_HOUR = 2;
  localparam int unsigned IDX_DOW  = 3;
  localparam int unsigned IDX_DOM  = 4;
  localparam int unsigned IDX_MON  = 5;
  localparam int unsigned IDX_YEAR = 6;
  localparam int unsigned IDX_CENT = 7;
  localparam int unsigned BYTE_N   = 8;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // take the load port into the binary counters
    logic advance;     // add one second to the binary counters
    logic writeBytes;  // copy converted counters into the BCD bytes
    logic clrValid;    // update begins
    logic setValid;    // update complete
  } calStrobe_t;

  // Binary 0..99 to packed BCD
  function automatic logic [7:0] toBcd(input logic [6:0] val);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = val / 7'd10;
    units = val - tens * 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       loadEn,
  output calStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_STAGE, ST_COMMIT} calState_t;

  calState_t state;
  calState_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (loadEn) begin
          strb.load     = 1'b1;
          strb.clrValid = 1'b1;
          stateNext     = ST_STAGE;
        end else if (secTick) begin
          strb.advance  = 1'b1;
          strb.clrValid = 1'b1;
          stateNext     = ST_STAGE;
        end
      end
      ST_STAGE: begin
        strb.writeBytes = 1'b1;
        stateNext       = ST_COMMIT;
      end
      ST_COMMIT: begin
        strb.setValid = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
#(
  parameter int unsigned YEAR_W    = 14,
  parameter int unsigned RST_YEAR  = 2000,
  parameter int unsigned RST_MON   = 0,
  parameter int unsigned RST_MDAY  = 1,
  parameter int unsigned RST_WDAY  = 6,
  parameter int unsigned LAST_YEAR = 9999
)(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic [5:0]        loadSec,
  input  logic [5:0]        loadMin,
  input  logic [4:0]        loadHour,
  input  logic [2:0]        loadWday,
  input  logic [4:0]        loadMday,
  input  logic [3:0]        loadMon,
  input  logic [YEAR_W-1:0] loadYear,
  output logic [7:0]        calByte [BYTE_N],
  output logic              timeValid,
  output logic              hour24
);

  localparam logic [YEAR_W-1:0] YEAR_LAST = YEAR_W'(LAST_YEAR);
  localparam logic [YEAR_W-1:0] YEAR_RST  = YEAR_W'(RST_YEAR);
  localparam logic [YEAR_W-1:0] HUNDRED   = YEAR_W'(100);

  // Binary counters
  logic [5:0]        sec, minute;
  logic [4:0]        hour;
  logic [2:0]        wday;
  logic [4:0]        mday;
  logic [3:0]        mon;
  logic [YEAR_W-1:0] year;

  // Century split and leap test
  logic [6:0] yrLo, yrHi;
  logic       leapYear;
  logic [4:0] monthDays;

  always_comb begin
    yrLo = 7'(year % HUNDRED);
    yrHi = 7'(year / HUNDRED);
    // a century year is leap only when its century count is a multiple of 4
    if (yrLo == 7'd0) leapYear = (yrHi[1:0] == 2'd0);
    else              leapYear = (yrLo[1:0] == 2'd0);
  end

  always_comb begin
    unique case (mon)
      4'd1:                      monthDays = leapYear ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   monthDays = 5'd30;
      default:                   monthDays = 5'd31;
    endcase
  end

  // Carry chain
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic [5:0]        secNext, minNext;
  logic [4:0]        hourNext, mdayNext;
  logic [2:0]        wdayNext;
  logic [3:0]        monNext;
  logic [YEAR_W-1:0] yearNext;

  always_comb begin
    secWrap  = (sec == 6'd59);
    minWrap  = secWrap && (minute == 6'd59);
    hourWrap = minWrap && (hour == 5'd23);
    dayWrap  = hourWrap && (mday == monthDays);
    monWrap  = dayWrap && (mon == 4'd11);

    secNext  = secWrap ? 6'd0 : sec + 6'd1;
    minNext  = !secWrap ? minute : (minWrap ? 6'd0 : minute + 6'd1);
    hourNext = !minWrap ? hour : (hourWrap ? 5'd0 : hour + 5'd1);
    wdayNext = !hourWrap ? wday : ((wday == 3'd6) ? 3'd0 : wday + 3'd1);
    mdayNext = !hourWrap ? mday : (dayWrap ? 5'd1 : mday + 5'd1);
    monNext  = !dayWrap ? mon : (monWrap ? 4'd0 : mon + 4'd1);
    yearNext = !monWrap ? year : ((year == YEAR_LAST) ? '0 : year + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec    <= '0;
      minute <= '0;
      hour   <= '0;
      wday   <= 3'(RST_WDAY);
      mday   <= 5'(RST_MDAY);
      mon    <= 4'(RST_MON);
      year   <= YEAR_RST;
    end else if (strb.load) begin
      sec    <= loadSec;
      minute <= loadMin;
      hour   <= loadHour;
      wday   <= loadWday;
      mday   <= loadMday;
      mon    <= loadMon;
      year   <= loadYear;
    end else if (strb.advance) begin
      sec    <= secNext;
      minute <= minNext;
      hour   <= hourNext;
      wday   <= wdayNext;
      mday   <= mdayNext;
      mon    <= monNext;
      year   <= yearNext;
    end
  end

  // Conversion to the published byte layout
  logic [7:0] byteNext [BYTE_N];

  always_comb begin
    byteNext[IDX_SEC]  = toBcd(7'(sec));
    byteNext[IDX_MIN]  = toBcd(7'(minute));
    byteNext[IDX_HOUR] = toBcd(7'(hour));
    byteNext[IDX_DOW]  = toBcd(7'(wday) + 7'd1);
    byteNext[IDX_DOM]  = toBcd(7'(mday));
    byteNext[IDX_MON]  = toBcd(7'(mon) + 7'd1);
    byteNext[IDX_YEAR] = toBcd(yrLo);
    byteNext[IDX_CENT] = toBcd(yrHi);
  end

  function automatic logic [7:0] resetByte(input int unsigned idx);
    case (idx)
      IDX_DOW:  return toBcd(7'(RST_WDAY + 1));
      IDX_DOM:  return toBcd(7'(RST_MDAY));
      IDX_MON:  return toBcd(7'(RST_MON + 1));
      IDX_YEAR: return toBcd(7'(RST_YEAR % 100));
      IDX_CENT: return toBcd(7'(RST_YEAR / 100));
      default:  return 8'h00;
    endcase
  endfunction

  for (genvar gi = 0; gi < BYTE_N; gi++) begin : g_byte
    localparam logic [7:0] RST_VAL = resetByte(gi);
    always_ff @(posedge clk) begin
      if (!rstN)                calByte[gi] <= RST_VAL;
      else if (strb.writeBytes) calByte[gi] <= byteNext[gi];
    end
  end

  // Status flags
  always_ff @(posedge clk) begin
    if (!rstN)              timeValid <= 1'b1;
    else if (strb.clrValid) timeValid <= 1'b0;
    else if (strb.setValid) timeValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hour24 <= 1'b1;
  end

endmodule

// File: rtl/calTimeKeeper.sv
module calTimeKeeper
  import calPkg::*;
#(
  parameter int unsigned YEAR_W   = 14,
  parameter int unsigned RST_YEAR = 2000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              loadEn,
  input  logic [5:0]        loadSec,
  input  logic [5:0]        loadMin,
  input  logic [4:0]        loadHour,
  input  logic [2:0]        loadWday,
  input  logic [4:0]        loadMday,
  input  logic [3:0]        loadMon,
  input  logic [YEAR_W-1:0] loadYear,
  output logic [7:0]        secBcd,
  output logic [7:0]        minBcd,
  output logic [7:0]        hourBcd,
  output logic [7:0]        dowBcd,
  output logic [7:0]        domBcd,
  output logic [7:0]        monBcd,
  output logic [7:0]        yearBcd,
  output logic [7:0]        centBcd,
  output logic              timeValid,
  output logic              hour24
);

  calStrobe_t strb;
  logic [7:0] calByte [BYTE_N];

  calCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .loadEn  (loadEn),
    .strb    (strb)
  );

  calDatapath #(
    .YEAR_W   (YEAR_W),
    .RST_YEAR (RST_YEAR),
    .RST_MON  (0),
    .RST_MDAY (1),
    .RST_WDAY (6),
    .LAST_YEAR(9999)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadSec   (loadSec),
    .loadMin   (loadMin),
    .loadHour  (loadHour),
    .loadWday  (loadWday),
    .loadMday  (loadMday),
    .loadMon   (loadMon),
    .loadYear  (loadYear),
    .calByte   (calByte),
    .timeValid (timeValid),
    .hour24    (hour24)
  );

  assign secBcd  = calByte[IDX_SEC];
  assign minBcd  = calByte[IDX_MIN];
  assign hourBcd = calByte[IDX_HOUR];
  assign dowBcd  = calByte[IDX_DOW];
  assign domBcd  = calByte[IDX_DOM];
  assign monBcd  = calByte[IDX_MON];
  assign yearBcd = calByte[IDX_YEAR];
  assign centBcd = calByte[IDX_CENT];

endmodule

// File: rtl/calTimeKeeperChk.sv
module calTimeKeeperChk (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic       loadEn,
  input logic [7:0] secBcd,
  input logic [7:0] minBcd,
  input logic [7:0] hourBcd,
  input logic [7:0] dowBcd,
  input logic [7:0] domBcd,
  input logic [7:0] monBcd,
  input logic [7:0] yearBcd,
  input logic [7:0] centBcd,
  input logic       timeValid,
  input logic       hour24
);

  logic [63:0] allBytes;
  assign allBytes = {secBcd, minBcd, hourBcd, dowBcd, domBcd, monBcd, yearBcd, centBcd};

  function automatic logic digitsOk(input logic [63:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    digitsOk(allBytes));

  // R3
  time_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    secBcd <= 8'h59 && minBcd <= 8'h59 && hourBcd <= 8'h23);

  // R4
  dow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dowBcd >= 8'h01 && dowBcd <= 8'h07);

  // R5
  month_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    monBcd >= 8'h01 && monBcd <= 8'h12);

  // R6
  dom_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    domBcd >= 8'h01 && domBcd <= 8'h31);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeValid && (secTick || loadEn) |=> !timeValid);

  // R8
  old_bytes_on_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeValid) |-> $stable(allBytes));

  // R8
  bytes_move_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(allBytes) |-> !timeValid);

  // R8
  low_two_cycles_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeValid) |=> !timeValid);

  // R1
  hour24_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    hour24);

endmodule

bind calTimeKeeper calTimeKeeperChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secTick   (secTick),
  .loadEn    (loadEn),
  .secBcd    (secBcd),
  .minBcd    (minBcd),
  .hourBcd   (hourBcd),
  .dowBcd    (dowBcd),
  .domBcd    (domBcd),
  .monBcd    (monBcd),
  .yearBcd   (yearBcd),
  .centBcd   (centBcd),
  .timeValid (timeValid),
  .hour24    (hour24)
);

// File: tb/sim_calTimeKeeper.sv
module sim_calTimeKeeper;

  localparam int CLK_PERIOD = 10;
  localparam int YEAR_W     = 14;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic loadEn = 1'b0;
  logic [5:0] loadSec = '0;
  logic [5:0] loadMin = '0;
  logic [4:0] loadHour = '0;
  logic [2:0] loadWday = '0;
  logic [4:0] loadMday = 5'd1;
  logic [3:0] loadMon = '0;
  logic [YEAR_W-1:0] loadYear = '0;
  logic [7:0] secBcd, minBcd, hourBcd, dowBcd, domBcd, monBcd, yearBcd, centBcd;
  logic timeValid, hour24;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model, binary, zero-based weekday and month
  int mSec, mMin, mHour, mWday, mMday, mMon, mYear;

  calTimeKeeper #(.YEAR_W(YEAR_W)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .loadEn(loadEn),
    .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
    .loadWday(loadWday), .loadMday(loadMday), .loadMon(loadMon),
    .loadYear(loadYear),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .dowBcd(dowBcd),
    .domBcd(domBcd), .monBcd(monBcd), .yearBcd(yearBcd), .centBcd(centBcd),
    .timeValid(timeValid), .hour24(hour24)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd8(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit isLeap(input int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int daysIn(input int m0, input int y);
    if (m0 == 1) return isLeap(y) ? 29 : 28;
    if (m0 == 3 || m0 == 5 || m0 == 8 || m0 == 10) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] expBytes();
    return {bcd8(mSec), bcd8(mMin), bcd8(mHour), bcd8(mWday + 1),
            bcd8(mMday), bcd8(mMon + 1), bcd8(mYear % 100), bcd8(mYear / 100)};
  endfunction

  function automatic logic [63:0] gotBytes();
    return {secBcd, minBcd, hourBcd, dowBcd, domBcd, monBcd, yearBcd, centBcd};
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mWday = (mWday + 1) % 7;
          mMday++;
          if (mMday > daysIn(mMon, mYear)) begin
            mMday = 1; mMon++;
            if (mMon == 12) begin
              mMon = 0;
              mYear = (mYear == 9999) ? 0 : mYear + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic checkBytes(input string req);
    checks++;
    if (gotBytes() !== expBytes()) begin
      fails++;
      $display("FAIL %s bytes got %h expected %h", req, gotBytes(), expBytes());
    end
  endtask

  task automatic checkBit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s flag got %b expected %b", req, got, exp);
    end
  endtask

  task automatic setLoad(input int s, input int mi, input int h, input int wd,
                         input int md, input int mo, input int y);
    loadSec = 6'(s); loadMin = 6'(mi); loadHour = 5'(h); loadWday = 3'(wd);
    loadMday = 5'(md); loadMon = 4'(mo); loadYear = YEAR_W'(y);
  endtask

  // pulse load (optionally with a coincident tick), wait for completion
  task automatic doLoad(input int s, input int mi, input int h, input int wd,
                        input int md, input int mo, input int y, input bit withTick);
    @(negedge clk);
    setLoad(s, mi, h, wd, md, mo, y);
    loadEn = 1'b1; secTick = withTick;
    @(negedge clk);
    loadEn = 1'b0; secTick = 1'b0;
    @(negedge clk); @(negedge clk);
    mSec = s; mMin = mi; mHour = h; mWday = wd; mMday = md; mMon = mo; mYear = y;
  endtask

  task automatic doTick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    @(negedge clk); @(negedge clk);
    modelTick();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired got running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    int dummy;
    dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values: 2000-01-01 Saturday 00:00:00
    mSec = 0; mMin = 0; mHour = 0; mWday = 6; mMday = 1; mMon = 0; mYear = 2000;
    checkBytes("R1");
    checkBit("R1", timeValid, 1'b1);
    checkBit("R1", hour24, 1'b1);

    // R8 cycle-exact update sequence
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);              // after edge k
    secTick = 1'b0;
    checkBit("R8", timeValid, 1'b0);
    checkBytes("R8");            // still old
    modelTick();
    @(negedge clk);              // after edge k+1
    checkBytes("R8");
    checkBit("R8", timeValid, 1'b0);
    @(negedge clk);              // after edge k+2
    checkBit("R8", timeValid, 1'b1);

    // R3 full cascade, R5 December to January, R7 year byte, R4 Sunday to Monday
    doLoad(59, 59, 23, 0, 31, 11, 2023, 0);
    checkBytes("R9");
    doTick();
    checkBytes("R3");
    checkBytes("R5");

    // R7 century carry 2099 -> 2100
    doLoad(59, 59, 23, 4, 31, 11, 2099, 0);
    doTick();
    checkBytes("R7");

    // R6 non-leap century year: Feb 28 2100 -> Mar 1
    doLoad(59, 59, 23, 0, 28, 1, 2100, 0);
    doTick();
    checkBytes("R6");
    // R6 leap 400-year: Feb 28 2000 -> Feb 29 -> Mar 1
    doLoad(59, 59, 23, 1, 28, 1, 2000, 0);
    doTick();
    checkBytes("R6");
    doLoad(59, 59, 23, 2, 29, 1, 2000, 0);
    doTick();
    checkBytes("R6");
    // R6 ordinary leap year and 30-day month
    doLoad(59, 59, 23, 3, 28, 1, 2024, 0);
    doTick();
    checkBytes("R6");
    doLoad(59, 59, 23, 2, 30, 3, 2025, 0);
    doTick();
    checkBytes("R6");

    // R4 Saturday (07) wraps to Sunday (01)
    doLoad(59, 59, 23, 6, 10, 4, 2025, 0);
    doTick();
    checkBytes("R4");

    // R9 coincident load and tick: load wins, no extra second
    doLoad(17, 42, 9, 3, 15, 6, 1987, 1);
    checkBytes("R9");

    // R10 tick and load while busy are ignored
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);               // accepted; now busy
    setLoad(0, 0, 0, 0, 1, 0, 1900);
    loadEn = 1'b1;                // held through both busy cycles
    @(negedge clk); @(negedge clk);
    secTick = 1'b0; loadEn = 1'b0;
    modelTick();
    checkBytes("R10");
    checkBit("R10", timeValid, 1'b1);

    // R2 R3 R6 constrained random loads followed by ticks
    for (int it = 0; it < 60; it++) begin
      int y, mo, md, h, mi, s, wd, nt;
      y  = 1900 + int'($urandom % 400);
      mo = int'($urandom % 12);
      if ($urandom % 2 == 0) begin
        md = daysIn(mo, y) - int'($urandom % 2);
        h  = 23; mi = 59; s = 55 + int'($urandom % 5);
      end else begin
        md = 1 + int'($urandom % daysIn(mo, y));
        h  = int'($urandom % 24); mi = int'($urandom % 60); s = int'($urandom % 60);
      end
      wd = int'($urandom % 7);
      doLoad(s, mi, h, wd, md, mo, y, 0);
      checkBytes("R2");
      nt = 1 + int'($urandom % 6);
      for (int k = 0; k < nt; k++) doTick();
      checkBytes("R3");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule